// File: doc/BRIEF.md
# Registered-Mode Output Macrocell Array

This block models the eight output cells of a small programmable logic device operating in its registered mode. Every cell receives a group of ready-made product terms from the AND array, a per-term disable mask, and two configuration bits of its own. One bit picks the cell's configuration: a clocked registered output or a combinational I/O. The other bit picks the output polarity. Each cell drives a pin model made of a data value and a drive enable. It also returns a feedback bit to the array.

Registered cells all use one shared clock pin and one shared active-low output-enable pin. An I/O cell spends one product term on its own tri-state enable. Holding that term low makes the cell a pure input, and holding it high makes the cell a permanent output. Two global bits select the device mode. Any combination other than the registered mode is reported as unsupported, and every pin is released while it is present.

The cell configuration is a two-valued enumeration: `CELL_REGOUT` and `CELL_IO`. The global decode has two named outcomes: `MODE_REG_OK` and `MODE_UNSUPPORTED`. There are no transitions other than a change of the configuration inputs. The only clocked state is one register per cell, cleared by reset.

Top module: `pld_regmode_cells`

## Requirements
- R1: The mode is valid only when `cfg_sync`=0 and `cfg_arch`=1. For any other pair, `cfg_bad`=1 and every bit of `pin_en` is 0.
- R2: A cell with `cell_io[c]`=0 is registered. On each rising `clk` it stores the OR of its eight enabled terms `pt_in[c*8+k]`, k=0..7.
- R3: A cell with `cell_io[c]`=1 drives combinationally from the OR of its enabled terms k=1..7. Term k=0 is left out of that sum.
- R4: With `cell_pol[c]`=1 the pin value equals the sum or the register, which is active high. With `cell_pol[c]`=0 it is the inverse, which is active low.
- R5: In a valid mode, `pin_en[c]` of a registered cell equals the inverse of `oe_pin_n`. All registered cells share this enable and the one clock.
- R6: In a valid mode, `pin_en[c]` of an I/O cell equals its enabled term k=0. A 0 makes the cell an input and a 1 makes it an output.
- R7: A term whose bit in `pt_dis` is 1 contributes 0 to every sum and to the enable term.
- R8: The feedback `fb[c]` of a registered cell is the inverted register. For an I/O cell it is `pin_out[c]` while `pin_en[c]`=1, and `pin_in[c]` otherwise.
- R9: While `rst_n`=0, every register is 0 at once. A registered cell then shows `pin_out[c]` = NOT `cell_pol[c]` and `fb[c]`=1.
- R10: Each cell follows its own configuration bits, whatever mix of registered and I/O cells is programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock pin for the registered cells |
| rst_n | input | 1 | Asynchronous active-low reset of all cell registers |
| oe_pin_n | input | 1 | Shared active-low output enable for the registered cells |
| cfg_sync | input | 1 | Global mode bit; must be 0 in registered mode |
| cfg_arch | input | 1 | Global mode bit; must be 1 in registered mode |
| cell_io | input | 8 | Per-cell configuration: 0 = registered, 1 = I/O |
| cell_pol | input | 8 | Per-cell polarity: 1 = active high, 0 = active low |
| pt_in | input | 64 | Product terms; term k of cell c at bit c*8+k |
| pt_dis | input | 64 | Per-term disable, same layout as `pt_in` |
| pin_in | input | 8 | Level seen on each pin from outside |
| pin_out | output | 8 | Value each cell drives onto its pin |
| pin_en | output | 8 | Drive enable of each pin |
| fb | output | 8 | Feedback to the AND array |
| cfg_bad | output | 1 | Unsupported global mode flag |

## Verification
The bench targets the enable term of an I/O cell. A design that summed it into the data path, or took its enable from the shared pin, would show a wrong pin value or drive direction once term 0 differs from the rest. It also checks that disabled terms are masked, including the enable term. A missing mask would turn outputs on or assert sums that should be 0. Both polarity settings are checked against reset. A wrong XOR sense, or a reset that clears the pin rather than the register, would show the wrong idle level. The bench also exercises unsupported mode pairs and feedback from a released I/O pin. A design that kept driving in a bad mode, or fed back its own value in place of the external level, would fail there.

// File: rtl/pld_rm_pkg.sv
package pld_rm_pkg;

    localparam int CELLS_DEF = 8;
    localparam int TERMS_DEF = 8;

    // per-cell configuration taken from the cell's own config bit
    typedef enum logic {
        CELL_REGOUT = 1'b0,
        CELL_IO     = 1'b1
    } cell_cfg_e;

    // outcome of the global mode decode
    typedef enum logic {
        MODE_REG_OK      = 1'b0,
        MODE_UNSUPPORTED = 1'b1
    } mode_e;

endpackage

// File: rtl/pld_rm_mode_dec.sv
module pld_rm_mode_dec
    import pld_rm_pkg::*;
(
    input  logic  cfg_sync,
    input  logic  cfg_arch,
    output mode_e mode
);

    always_comb begin
        unique case ({cfg_sync, cfg_arch})
            2'b01:   mode = MODE_REG_OK;
            default: mode = MODE_UNSUPPORTED;
        endcase
    end

endmodule

// File: rtl/pld_rm_term_sum.sv
module pld_rm_term_sum #(
    parameter int NTERM = 8,
    parameter int FIRST = 0
) (
    input  logic [NTERM-1:0] terms,
    input  logic [NTERM-1:0] dis,
    output logic             sum
);

    localparam int LAST = NTERM - 1;

    logic [NTERM-1:0] live;

    // a disabled term contributes a zero
    assign live = terms & ~dis;

    always_comb begin
        sum = 1'b0;
        for (int k = FIRST; k <= LAST; k++) begin
            sum = sum | live[k];
        end
    end

endmodule

// File: rtl/pld_rm_cell.sv
module pld_rm_cell
    import pld_rm_pkg::*;
#(
    parameter int NTERM = TERMS_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_ok,
    input  logic             oe_pin_n,
    input  logic             cfg_io,
    input  logic             pol,
    input  logic [NTERM-1:0] terms,
    input  logic [NTERM-1:0] dis,
    input  logic             pin_in,
    output logic             pin_out,
    output logic             pin_en,
    output logic             fb
);

    localparam int EN_TERM = 0;

    cell_cfg_e cfg;
    logic      sum_all;
    logic      sum_tail;
    logic      en_term;
    logic      q_r;
    logic      data;
    logic      en_raw;

    assign cfg     = cell_cfg_e'(cfg_io);
    assign en_term = terms[EN_TERM] & ~dis[EN_TERM];

    // full sum for the register path
    pld_rm_term_sum #(.NTERM(NTERM), .FIRST(0)) sum_all_i (
        .terms (terms),
        .dis   (dis),
        .sum   (sum_all)
    );

    // sum without the enable term for the I/O path
    pld_rm_term_sum #(.NTERM(NTERM), .FIRST(EN_TERM + 1)) sum_tail_i (
        .terms (terms),
        .dis   (dis),
        .sum   (sum_tail)
    );

    // state register: one flop clocked by the shared clock pin
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_r <= 1'b0;
        end else begin
            q_r <= sum_all;
        end
    end

    // output process: selects data, enable and feedback per configuration
    always_comb begin
        unique case (cfg)
            CELL_REGOUT: begin
                data   = q_r;
                en_raw = ~oe_pin_n;
            end
            CELL_IO: begin
                data   = sum_tail;
                en_raw = en_term;
            end
            default: begin
                data   = 1'b0;
                en_raw = 1'b0;
            end
        endcase
        pin_out = pol ? data : ~data;
        pin_en  = mode_ok & en_raw;
        unique case (cfg)
            CELL_REGOUT: fb = ~q_r;
            CELL_IO:     fb = pin_en ? pin_out : pin_in;
            default:     fb = 1'b0;
        endcase
    end

    // R2
    reg_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (q_r == $past(sum_all)));

endmodule

// File: rtl/pld_regmode_cells.sv
module pld_regmode_cells
    import pld_rm_pkg::*;
#(
    parameter int NCELL = CELLS_DEF,
    parameter int NTERM = TERMS_DEF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   oe_pin_n,
    input  logic                   cfg_sync,
    input  logic                   cfg_arch,
    input  logic [NCELL-1:0]       cell_io,
    input  logic [NCELL-1:0]       cell_pol,
    input  logic [NCELL*NTERM-1:0] pt_in,
    input  logic [NCELL*NTERM-1:0] pt_dis,
    input  logic [NCELL-1:0]       pin_in,
    output logic [NCELL-1:0]       pin_out,
    output logic [NCELL-1:0]       pin_en,
    output logic [NCELL-1:0]       fb,
    output logic                   cfg_bad
);

    mode_e mode;
    logic  mode_ok;

    pld_rm_mode_dec mode_dec_i (
        .cfg_sync (cfg_sync),
        .cfg_arch (cfg_arch),
        .mode     (mode)
    );

    assign mode_ok = (mode == MODE_REG_OK);
    assign cfg_bad = ~mode_ok;

    for (genvar c = 0; c < NCELL; c++) begin : g_cell
        pld_rm_cell #(.NTERM(NTERM)) cell_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode_ok  (mode_ok),
            .oe_pin_n (oe_pin_n),
            .cfg_io   (cell_io[c]),
            .pol      (cell_pol[c]),
            .terms    (pt_in[c*NTERM +: NTERM]),
            .dis      (pt_dis[c*NTERM +: NTERM]),
            .pin_in   (pin_in[c]),
            .pin_out  (pin_out[c]),
            .pin_en   (pin_en[c]),
            .fb       (fb[c])
        );

        // R5
        shared_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_bad && !cell_io[c]) |-> (pin_en[c] == !oe_pin_n));

        // R8
        io_input_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cell_io[c] && !pin_en[c]) |-> (fb[c] == pin_in[c]));
    end

    // R1
    bad_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bad |-> (pin_en == '0));

endmodule

// File: tb/pld_regmode_cells_tb.sv
module pld_regmode_cells_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;

    typedef struct packed {
        logic        sync;
        logic        arch;
        logic        oe_n;
        logic [7:0]  io;
        logic [7:0]  pol;
        logic [63:0] pt;
        logic [63:0] dis;
        logic [7:0]  pin;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 1'b0, 8'h00, 8'hFF, 64'h8000_0100_0000_00FF, 64'h0, 8'h00},
        '{1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 64'h8000_0100_0000_00FF, 64'h0, 8'h00},
        '{1'b0, 1'b1, 1'b0, 8'hFF, 8'hAA, 64'h01FE_00FF_FE01_0102, 64'h0, 8'h5A},
        '{1'b0, 1'b1, 1'b1, 8'h0F, 8'h3C, 64'hFFFF_0000_8001_7F7E, 64'h00FF_0000_0000_0101, 8'hC3},
        '{1'b0, 1'b1, 1'b0, 8'hF0, 8'h0F, 64'h1234_5678_9ABC_DEF0, 64'hF0F0_0F0F_FF00_00FF, 8'h96},
        '{1'b1, 1'b1, 1'b0, 8'h55, 8'h33, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        oe_pin_n = 1'b0;
    logic        cfg_sync = 1'b0;
    logic        cfg_arch = 1'b1;
    logic [7:0]  cell_io = '0;
    logic [7:0]  cell_pol = '0;
    logic [63:0] pt_in = '0;
    logic [63:0] pt_dis = '0;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out;
    logic [7:0]  pin_en;
    logic [7:0]  fb;
    logic        cfg_bad;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pld_regmode_cells dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .oe_pin_n (oe_pin_n),
        .cfg_sync (cfg_sync),
        .cfg_arch (cfg_arch),
        .cell_io  (cell_io),
        .cell_pol (cell_pol),
        .pt_in    (pt_in),
        .pt_dis   (pt_dis),
        .pin_in   (pin_in),
        .pin_out  (pin_out),
        .pin_en   (pin_en),
        .fb       (fb),
        .cfg_bad  (cfg_bad)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        cfg_sync = v.sync;
        cfg_arch = v.arch;
        oe_pin_n = v.oe_n;
        cell_io  = v.io;
        cell_pol = v.pol;
        pt_in    = v.pt;
        pt_dis   = v.dis;
        pin_in   = v.pin;
    endtask

    // expected values from the requirements, assuming inputs held across one rising edge
    task automatic model(input vec_t v, output logic [7:0] eo, output logic [7:0] een,
                         output logic [7:0] efb, output logic ebad);
        logic [63:0] live;
        live = v.pt & ~v.dis;
        ebad = !(v.sync == 1'b0 && v.arch == 1'b1);
        for (int c = 0; c < 8; c++) begin
            logic s8, s7, e0, d;
            s8 = |live[c*8 +: 8];
            s7 = |live[c*8+1 +: 7];
            e0 = live[c*8];
            d  = v.io[c] ? s7 : s8;
            eo[c]  = v.pol[c] ? d : ~d;
            een[c] = ebad ? 1'b0 : (v.io[c] ? e0 : ~v.oe_n);
            efb[c] = v.io[c] ? (een[c] ? eo[c] : v.pin[c]) : ~s8;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] eo, een, efb;
        logic       ebad;
        vec_t       d;

        // reset state: all registered, mixed polarity
        cell_pol = 8'hA5;
        pt_in    = '1;
        repeat (3) @(negedge clk);
        check("R9 reset pin level", pin_out, ~8'hA5);
        check("R9 reset feedback", fb, 8'hFF);
        @(negedge clk);
        rst_n = 1'b1;

        // table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VECS[i]);
            model(VECS[i], eo, een, efb, ebad);
            @(negedge clk);
            check("R2 R3 R4 R7 R10 pin value", pin_out, eo);
            check("R1 R5 R6 drive enable", pin_en, een);
            check("R8 feedback", fb, efb);
            check("R1 mode flag", {7'b0, cfg_bad}, {7'b0, ebad});
        end

        // unsupported pair 0/0
        d = VECS[2];
        d.sync = 1'b0;
        d.arch = 1'b0;
        @(negedge clk);
        apply(d);
        @(negedge clk);
        check("R1 sync0 arch0 flag", {7'b0, cfg_bad}, 8'h01);
        check("R1 sync0 arch0 pins released", pin_en, 8'h00);
        check("R8 released io feeds pin_in", fb, d.pin);

        // every term disabled: registered sums and io enables go to 0
        d = '{1'b0, 1'b1, 1'b0, 8'h0F, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF,
              64'hFFFF_FFFF_FFFF_FFFF, 8'h3C};
        @(negedge clk);
        apply(d);
        @(negedge clk);
        check("R7 all disabled pin value", pin_out, 8'h00);
        check("R7 all disabled io enable", pin_en, 8'hF0);

        // io cell: enable term only, data terms low -> driven output of 0 (pol=1)
        d = '{1'b0, 1'b1, 1'b1, 8'hFF, 8'hFF, 64'h0101_0101_0101_0101, 64'h0, 8'hFF};
        @(negedge clk);
        apply(d);
        #1;
        check("R3 enable term excluded from sum", pin_out, 8'h00);
        check("R6 enable term drives output", pin_en, 8'hFF);

        // registered cells hold state with shared OE released
        d = '{1'b0, 1'b1, 1'b1, 8'h00, 8'hFF, 64'h00FF_00FF_00FF_00FF, 64'h0, 8'h00};
        @(negedge clk);
        apply(d);
        @(negedge clk);
        check("R5 shared OE high releases registered pins", pin_en, 8'h00);
        check("R2 register content via pin", pin_out, 8'h55);

        // asynchronous reset mid-run
        #1;
        rst_n = 1'b0;
        #1;
        check("R9 async clear feedback", fb, 8'hFF);
        check("R9 async clear pin level", pin_out, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule